// File: doc/BRIEF.md
# Timer Trigger-Event PWM Output

This block turns the overflow and match strobes of a timer counter into a PWM pin value. A two-bit trigger mode chooses which counter events act on the pin. A shape bit chooses the response. In pulse shape, each chosen event inverts the pin for one prescaled counter tick. In toggle shape, each chosen event flips the pin, and the pin keeps its new level.

The pin rests at a programmable idle level while the timer is stopped or no trigger mode is selected. A separate direction bit drives the pin's output enable. When the enable is off, the pin is released for capture use.

The counter and the prescaler sit outside the block. They supply a run flag, a prescaled tick strobe and the event strobes. Overflow and match strobes are only expected in cycles where the tick strobe is also high.

Top module: `pwm_trig_out`

## Requirements
- R1: The trigger mode encoding is as follows. Mode 0 means no trigger. Mode 1 means overflow only, so the match strobe has no effect. Mode 2 means overflow and match: either strobe is a selected event.
- R2: The reserved trigger mode 3 behaves exactly as mode 0: the pin sits at the idle level and events have no effect.
- R3: The pin equals the idle level in the same cycle whenever the run flag is low or the trigger mode is 0 or 3.
- R4: Pulse shape is selected by shape bit 0. A selected event sampled at a clock edge sets the pin to the inverse of the idle level from that edge onward. The pin returns to the idle level at the edge of the next tick strobe that carries no selected event.
- R5: Toggle shape is selected by shape bit 1. Each selected event sampled at a clock edge inverts the pin from that edge on, and the pin holds that level until the next selected event.
- R6: Suppose the timer was stopped, or in mode 0 or 3, for at least one clock edge before it is enabled. Then the pin starts at the idle level when it is enabled, in both shapes.
- R7: The output enable is 1 when the direction bit is 0 (pin drives) and 0 when the direction bit is 1 (pin is an input).
- R8: Event strobes that arrive while the run flag is low leave no trace. The first enabled cycle still shows the idle level.
- R9: In mode 2, an overflow and a match in the same cycle count as one event. In toggle shape they invert the pin once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Timer running flag |
| tick_i | input | 1 | Prescaled counter tick strobe |
| ovf_i | input | 1 | Counter overflow strobe |
| match_i | input | 1 | Compare match strobe |
| trig_mode_i | input | 2 | Trigger mode: 0 none, 1 overflow, 2 overflow and match, 3 reserved |
| toggle_i | input | 1 | Shape: 0 pulse, 1 toggle |
| idle_lvl_i | input | 1 | Pin level while idle |
| pin_dir_i | input | 1 | Direction: 0 output, 1 input |
| pwm_o | output | 1 | PWM pin value |
| pwm_oe_o | output | 1 | Pin output enable |

## Verification
Idle forcing and the output enable are combinational, so the bench checks them in the same cycle the inputs change. Event effects pass through a single state register, so they are due one clock edge after the strobe. Pulse release is due at the edge of the next tick strobe. The bench drives all inputs on the falling edge and samples on the following falling edge. This keeps each result exactly one rising edge after its stimulus. The pulse release is checked both one cycle before that tick edge, when the pin must still be inverted, and one cycle after it.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_OVF   = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_RSVD  = 2'd3
  } trig_mode_e;

  // reserved encoding folds onto "none"
  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return (m == TRIG_OVF) || (m == TRIG_BOTH);
  endfunction
endpackage

// File: rtl/pwm_evt_sel.sv
module pwm_evt_sel
  import pwm_trig_pkg::*;
(
  input  logic              run_i,
  input  logic              ovf_i,
  input  logic              match_i,
  input  logic [MODE_W-1:0] trig_mode_i,
  output logic              active_o,
  output logic              evt_o
);
  always_comb begin
    active_o = run_i && mode_active(trig_mode_i);
    evt_o    = 1'b0;
    if (active_o) begin
      unique case (trig_mode_i)
        TRIG_OVF:  evt_o = ovf_i;
        TRIG_BOTH: evt_o = ovf_i | match_i;
        default:   evt_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic evt_i,
  input  logic tick_i,
  input  logic idle_lvl_i,
  output logic pulse_q_o,
  output logic tog_q_o
);
  logic pulse_q, tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else if (!active_i) begin
      pulse_q <= 1'b0;
      tog_q   <= idle_lvl_i;
    end else begin
      if (evt_i)       pulse_q <= 1'b1;
      else if (tick_i) pulse_q <= 1'b0;
      if (evt_i)       tog_q   <= ~tog_q;
    end
  end

  assign pulse_q_o = pulse_q;
  assign tog_q_o   = tog_q;
endmodule

// File: rtl/pwm_trig_out.sv
module pwm_trig_out
  import pwm_trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              ovf_i,
  input  logic              match_i,
  input  logic [MODE_W-1:0] trig_mode_i,
  input  logic              toggle_i,
  input  logic              idle_lvl_i,
  input  logic              pin_dir_i,
  output logic              pwm_o,
  output logic              pwm_oe_o
);
  logic active, evt, pulse_q, tog_q;

  pwm_evt_sel u_sel (
    .run_i       (run_i),
    .ovf_i       (ovf_i),
    .match_i     (match_i),
    .trig_mode_i (trig_mode_i),
    .active_o    (active),
    .evt_o       (evt)
  );

  pwm_wave_gen u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .evt_i      (evt),
    .tick_i     (tick_i),
    .idle_lvl_i (idle_lvl_i),
    .pulse_q_o  (pulse_q),
    .tog_q_o    (tog_q)
  );

  always_comb begin
    if (!active)       pwm_o = idle_lvl_i;
    else if (toggle_i) pwm_o = tog_q;
    else               pwm_o = idle_lvl_i ^ pulse_q;
  end

  assign pwm_oe_o = ~pin_dir_i;
endmodule

// File: rtl/pwm_trig_out_chk.sv
module pwm_trig_out_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       ovf_i,
  input logic       match_i,
  input logic [1:0] trig_mode_i,
  input logic       toggle_i,
  input logic       idle_lvl_i,
  input logic       pin_dir_i,
  input logic       pwm_o,
  input logic       pwm_oe_o
);
  // R3
  stopped_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || trig_mode_i == 2'd0) |-> (pwm_o == idle_lvl_i));

  // R2
  reserved_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_mode_i == 2'd3) |-> (pwm_o == idle_lvl_i));

  // R5
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && toggle_i && trig_mode_i == 2'd1 && ovf_i) |=>
    (!(run_i && $stable(toggle_i) && $stable(trig_mode_i) && $stable(idle_lvl_i))
     || (pwm_o != $past(pwm_o))));

  // R1
  match_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && toggle_i && trig_mode_i == 2'd1 && match_i && !ovf_i) |=>
    (!(run_i && $stable(toggle_i) && $stable(trig_mode_i) && $stable(idle_lvl_i))
     || (pwm_o == $past(pwm_o))));

  // R4
  pulse_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !toggle_i && trig_mode_i == 2'd2 && (ovf_i || match_i)) |=>
    (!(run_i && $stable(toggle_i) && $stable(trig_mode_i) && $stable(idle_lvl_i))
     || (pwm_o != idle_lvl_i)));

  // R7
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_dir_i) |-> !pwm_oe_o);
endmodule

bind pwm_trig_out pwm_trig_out_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .ovf_i       (ovf_i),
  .match_i     (match_i),
  .trig_mode_i (trig_mode_i),
  .toggle_i    (toggle_i),
  .idle_lvl_i  (idle_lvl_i),
  .pin_dir_i   (pin_dir_i),
  .pwm_o       (pwm_o),
  .pwm_oe_o    (pwm_oe_o)
);

// File: tb/pwm_trig_out_test.sv
module pwm_trig_out_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, tick = 0, ovf = 0, mtc = 0, tgl = 0, idle = 0, dir = 0;
  logic [1:0] mode = 2'd0;
  logic pwm, oe;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pwm_trig_out uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .tick_i(tick), .ovf_i(ovf),
    .match_i(mtc), .trig_mode_i(mode), .toggle_i(tgl), .idle_lvl_i(idle),
    .pin_dir_i(dir), .pwm_o(pwm), .pwm_oe_o(oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one rising edge with given strobes, then strobes cleared
  task automatic step(input logic t, input logic o, input logic m);
    tick = t; ovf = o; mtc = m;
    @(negedge clk);
    tick = 0; ovf = 0; mtc = 0;
  endtask

  task automatic setup(input logic r, input logic [1:0] md, input logic tg, input logic il);
    run = 0; mode = md; tgl = tg; idle = il;
    step(0, 0, 0);
    run = r;
    #1;
  endtask

  task automatic t_reset;
    chk("R3 reset idle", pwm, 1'b0);
    chk("R7 reset oe", oe, 1'b1);
  endtask

  task automatic t_oe;
    dir = 1; #1; chk("R7 dir in", oe, 1'b0);
    dir = 0; #1; chk("R7 dir out", oe, 1'b1);
  endtask

  task automatic t_stopped;
    setup(0, 2'd2, 1, 1);
    chk("R3 stopped idle1", pwm, 1'b1);
    step(1, 1, 1);
    chk("R8 stopped event", pwm, 1'b1);
    run = 1; #1;
    chk("R8 first enabled cycle", pwm, 1'b1);
    mode = 2'd0; #1;
    chk("R3 mode none", pwm, 1'b1);
    idle = 0; #1;
    chk("R3 mode none idle0", pwm, 1'b0);
  endtask

  task automatic t_toggle;
    setup(1, 2'd1, 1, 0);
    chk("R6 toggle start", pwm, 1'b0);
    step(1, 1, 0);
    chk("R5 toggle first", pwm, 1'b1);
    step(1, 0, 0); step(0, 0, 0); step(1, 0, 0);
    chk("R5 toggle hold", pwm, 1'b1);
    step(1, 1, 0);
    chk("R5 toggle second", pwm, 1'b0);
  endtask

  task automatic t_match;
    setup(1, 2'd1, 1, 0);
    step(1, 0, 1);
    chk("R1 match ignored mode1", pwm, 1'b0);
    mode = 2'd2;
    step(1, 0, 1);
    chk("R1 match in mode2", pwm, 1'b1);
    step(1, 1, 1);
    chk("R9 joint event once", pwm, 1'b0);
  endtask

  task automatic t_reserved;
    setup(1, 2'd3, 1, 1);
    chk("R2 reserved idle", pwm, 1'b1);
    step(1, 1, 1);
    chk("R2 reserved event", pwm, 1'b1);
    mode = 2'd1; #1;
    chk("R6 leave reserved", pwm, 1'b1);
  endtask

  task automatic t_pulse;
    setup(1, 2'd2, 0, 0);
    chk("R6 pulse start", pwm, 1'b0);
    step(1, 1, 0);
    chk("R4 pulse set", pwm, 1'b1);
    step(0, 0, 0); step(0, 0, 0);
    chk("R4 pulse held before tick", pwm, 1'b1);
    step(1, 0, 0);
    chk("R4 pulse released", pwm, 1'b0);
    idle = 1;
    step(1, 0, 1);
    chk("R4 pulse idle1 set", pwm, 1'b0);
    step(1, 1, 0);
    chk("R4 pulse extended", pwm, 1'b0);
    step(1, 0, 0);
    chk("R4 pulse idle1 released", pwm, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_oe();
    t_stopped();
    t_toggle();
    t_match();
    t_reserved();
    t_pulse();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule